// File: doc/BRIEF.md
# Internal Data Memory Router

This block is the internal data store of an 8-bit microcontroller core. It holds 256 bytes of RAM and a 128-byte file of special function registers, and it routes each access to the right place. An access carries an 8-bit address and a two-bit mode tag. In direct mode the address is used as it stands. In register mode the address names one of eight working registers in the active bank. In indirect mode the block reads a working register and uses its contents as the RAM address.

The upper half of the address range behaves differently in each mode. Under direct addressing it reaches the register file. Under indirect addressing it reaches the upper 128 bytes of RAM. The active register bank comes from bits 4:3 of the status byte, which sits in the register file. A separate 16-bit port loads the data pointer, which occupies a high/low register pair, and the pointer is also driven out as a 16-bit value.

Reads return one cycle after the access is accepted. A write also returns the byte that was at the location before the write.

Top module: `idata_router`

## Requirements
- R1: After reset `rdValid` is 0, `dptr` is 0x0000 and `bank` is 0.
- R2: With mode 2'b00 (direct) and address bit 7 equal to 0, the access reaches RAM byte `addr[6:0]`.
- R3: With mode 2'b00 (direct) and address bit 7 equal to 1, the access reaches register `addr[6:0]` of the special function register file. It never reaches upper RAM.
- R4: With mode 2'b10 (indirect), the access reaches the RAM byte whose address is the full contents of working register R0 (`addr[0]`=0) or R1 (`addr[0]`=1) of the active bank. This covers all 256 bytes, including the upper 128.
- R5: With mode 2'b01 (register), the access reaches RAM byte `bank*8 + addr[2:0]`.
- R6: `bank` equals bits 4:3 of the status register at direct address 0xD0. It follows a write to that register from the next cycle.
- R7: A 16-bit pointer load puts the upper byte at direct address 0x83 and the lower byte at 0x82. `dptr` shows {0x83, 0x82} on the following cycle.
- R8: Each accepted access raises `rdValid` for exactly the next cycle, with `rdData` valid alongside it.
- R9: A write returns the location's old contents on `rdData`. The new value is seen by the next access.
- R10: A location that has never been written reads as zero. Mode 2'b11 behaves as direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accMode | input | 2 | 00 direct, 01 register, 10 indirect, 11 treated as direct |
| accAddr | input | 8 | Direct address, register number (bits 2:0) or pointer select (bit 0) |
| wrData | input | 8 | Write byte |
| dptrWe | input | 1 | Load the 16-bit data pointer |
| dptrWrData | input | 16 | Pointer value to load |
| rdData | output | 8 | Byte at the location before the access |
| rdValid | output | 1 | rdData is valid |
| dptr | output | 16 | Current data pointer |
| bank | output | 2 | Active register bank |

## Verification
Read results are due one cycle after the access is accepted. Writes to the status byte and pointer loads show on `bank` and `dptr` one cycle later. The bench drives inputs on the falling edge, so each access is captured on the next rising edge. Every access pushes its expected byte into a queue. The monitor pops one entry on each falling edge where `rdValid` is high, which keeps each comparison aligned to the one-cycle latency. The `bank` and `dptr` checks sample one falling edge after their write.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int SFR_W    = ADDR_W - 1;
  localparam int RAM_SIZE = 1 << ADDR_W;
  localparam int SFR_SIZE = 1 << SFR_W;
  localparam int REG_W    = 3;
  localparam int BANK_W   = 2;
  localparam logic [SFR_W-1:0] SFR_STATUS = 7'h50;
  localparam logic [SFR_W-1:0] SFR_PTR_LO = 7'h02;
  localparam logic [SFR_W-1:0] SFR_PTR_HI = 7'h03;
  localparam int BANK_LSB = 3;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_REG    = 2'b01,
    MODE_IND    = 2'b10,
    MODE_RSVD   = 2'b11
  } accMode_e;

  typedef struct packed {
    logic              go;
    logic              wr;
    logic              toSfr;
    logic [ADDR_W-1:0] ramIdx;
    logic [SFR_W-1:0]  sfrIdx;
  } strobe_t;
endpackage

// File: rtl/idata_ctrl.sv
module idata_ctrl
  import idata_pkg::*;
(
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [1:0]        accMode,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] ptrR0,
  input  logic [DATA_W-1:0] ptrR1,
  output strobe_t           stb
);
  accMode_e modeE;
  assign modeE = accMode_e'(accMode);

  always_comb begin
    stb        = '0;
    stb.go     = accValid;
    stb.wr     = accValid & accWrite;
    stb.sfrIdx = accAddr[SFR_W-1:0];
    unique case (modeE)
      MODE_REG: begin
        stb.toSfr  = 1'b0;
        stb.ramIdx = {{(ADDR_W-BANK_W-REG_W){1'b0}}, bank, accAddr[REG_W-1:0]};
      end
      MODE_IND: begin
        stb.toSfr  = 1'b0;
        stb.ramIdx = accAddr[0] ? ptrR1 : ptrR0;
      end
      default: begin
        stb.toSfr  = accAddr[ADDR_W-1];
        stb.ramIdx = {1'b0, accAddr[SFR_W-1:0]};
      end
    endcase
  end
endmodule

// File: rtl/idata_dpath.sv
module idata_dpath
  import idata_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                dptrWe,
  input  logic [2*DATA_W-1:0] dptrWrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic [2*DATA_W-1:0] dptr,
  output logic [BANK_W-1:0]   bank,
  output logic [DATA_W-1:0]   ptrR0,
  output logic [DATA_W-1:0]   ptrR1
);
  logic [DATA_W-1:0] ram [RAM_SIZE];
  logic [DATA_W-1:0] sfr [SFR_SIZE];
  logic [DATA_W-1:0] oldByte;
  logic [DATA_W-1:0] statusByte;

  assign statusByte = sfr[SFR_STATUS];
  assign bank  = statusByte[BANK_LSB +: BANK_W];
  assign ptrR0 = ram[{{(ADDR_W-BANK_W-REG_W){1'b0}}, bank, 3'd0}];
  assign ptrR1 = ram[{{(ADDR_W-BANK_W-REG_W){1'b0}}, bank, 3'd1}];
  assign dptr  = {sfr[SFR_PTR_HI], sfr[SFR_PTR_LO]};
  assign oldByte = stb.toSfr ? sfr[stb.sfrIdx] : ram[stb.ramIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_SIZE; i++) ram[i] <= '0;
    end else if (stb.wr && !stb.toSfr) begin
      ram[stb.ramIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SFR_SIZE; i++) sfr[i] <= '0;
    end else begin
      if (stb.wr && stb.toSfr) sfr[stb.sfrIdx] <= wrData;
      if (dptrWe) begin
        sfr[SFR_PTR_HI] <= dptrWrData[2*DATA_W-1:DATA_W];
        sfr[SFR_PTR_LO] <= dptrWrData[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.go;
      if (stb.go) rdData <= oldByte;
    end
  end
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idata_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [1:0]  accMode,
  input  logic [7:0]  accAddr,
  input  logic [7:0]  wrData,
  input  logic        dptrWe,
  input  logic [15:0] dptrWrData,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic [15:0] dptr,
  output logic [1:0]  bank
);
  strobe_t stb;
  logic [DATA_W-1:0] ptrR0, ptrR1;

  idata_ctrl u_ctrl (
    .accValid(accValid), .accWrite(accWrite), .accMode(accMode),
    .accAddr(accAddr), .bank(bank), .ptrR0(ptrR0), .ptrR1(ptrR1), .stb(stb)
  );

  idata_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData),
    .dptrWe(dptrWe), .dptrWrData(dptrWrData), .rdData(rdData),
    .rdValid(rdValid), .dptr(dptr), .bank(bank), .ptrR0(ptrR0), .ptrR1(ptrR1)
  );
endmodule

// File: rtl/idata_router_chk.sv
module idata_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accValid,
  input logic        accWrite,
  input logic [1:0]  accMode,
  input logic [7:0]  accAddr,
  input logic [7:0]  wrData,
  input logic        dptrWe,
  input logic [15:0] dptrWrData,
  input logic [7:0]  rdData,
  input logic        rdValid,
  input logic [15:0] dptr,
  input logic [1:0]  bank
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> rdValid); // R8
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> !rdValid); // R8
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dptrWe |=> dptr == $past(dptrWrData)); // R7
  AST_BANK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accWrite && accMode == 2'b00 && accAddr == 8'hD0 && !dptrWe)
    |=> bank == $past(wrData[4:3])); // R6
  AST_LOW_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accValid && accWrite && accMode == 2'b00 && !accAddr[7]) &&
     accValid && !accWrite && accMode == 2'b00 && accAddr == $past(accAddr))
    |=> rdData == $past(wrData, 2)); // R2
endmodule

bind idata_router idata_router_chk u_chk (.*);

// File: tb/idata_router_tb.sv
module idata_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [1:0] accMode = 2'b00;
  logic [7:0] accAddr = '0, wrData = '0;
  logic dptrWe = 1'b0;
  logic [15:0] dptrWrData = '0;
  logic [7:0] rdData;
  logic rdValid;
  logic [15:0] dptr;
  logic [1:0] bank;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] mRam [256];
  logic [7:0] mSfr [128];
  logic [7:0] expQ [$];
  string tagQ [$];

  always #2.5 clk = ~clk;

  idata_router u_dut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] mBank();
    logic [7:0] s;
    s = mSfr[7'h50];
    return s[4:3];
  endfunction

  task automatic access(input logic [1:0] mode, input logic [7:0] addr,
                        input logic we, input logic [7:0] d, input string tag);
    logic isSfr;
    logic [7:0] idx;
    logic [7:0] old;
    isSfr = 1'b0;
    case (mode)
      2'b01: idx = {3'b000, mBank(), addr[2:0]};
      2'b10: idx = mRam[{3'b000, mBank(), 2'b00, addr[0]}];
      default: begin isSfr = addr[7]; idx = {1'b0, addr[6:0]}; end
    endcase
    old = isSfr ? mSfr[idx[6:0]] : mRam[idx];
    if (we) begin
      if (isSfr) mSfr[idx[6:0]] = d; else mRam[idx] = d;
    end
    @(negedge clk);
    accValid = 1'b1; accWrite = we; accMode = mode; accAddr = addr; wrData = d;
    expQ.push_back(old);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; dptrWe = 1'b0;
  endtask

  task automatic loadPtr(input logic [15:0] v);
    @(negedge clk);
    accValid = 1'b0; dptrWe = 1'b1; dptrWrData = v;
    mSfr[7'h03] = v[15:8];
    mSfr[7'h02] = v[7:0];
  endtask

  always @(negedge clk) begin
    if (rst_n && rdValid) begin
      if (expQ.size() == 0) begin
        check("R8 unexpected rdValid", 16'd1, 16'd0);
      end else begin
        check(tagQ.pop_front(), {8'h00, rdData}, {8'h00, expQ.pop_front()});
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mRam[i] = '0;
    for (int i = 0; i < 128; i++) mSfr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdValid", {15'd0, rdValid}, 16'd0);
    check("R1 dptr", dptr, 16'h0000);
    check("R1 bank", {14'd0, bank}, 16'd0);
    access(2'b00, 8'h10, 1'b0, 8'h00, "R10 unwritten lower");
    access(2'b10, 8'h00, 1'b0, 8'h00, "R10 unwritten indirect");
    access(2'b00, 8'h05, 1'b1, 8'hA5, "R9 write returns old");
    access(2'b00, 8'h05, 1'b0, 8'h00, "R2 direct readback");
    access(2'b00, 8'h90, 1'b1, 8'h3C, "R3 sfr write");
    access(2'b00, 8'h00, 1'b1, 8'h90, "R2 set R0");
    access(2'b10, 8'h00, 1'b0, 8'h00, "R3 upper RAM untouched by direct");
    access(2'b10, 8'h00, 1'b1, 8'h77, "R4 indirect write");
    access(2'b00, 8'h90, 1'b0, 8'h00, "R3 sfr kept apart from upper RAM");
    access(2'b10, 8'h00, 1'b0, 8'h00, "R4 indirect read upper");
    access(2'b01, 8'h03, 1'b1, 8'h11, "R5 reg write bank0");
    access(2'b00, 8'h03, 1'b0, 8'h00, "R5 bank0 R3 location");
    access(2'b00, 8'hD0, 1'b1, 8'h10, "R6 status write");
    idle();
    check("R6 bank after status write", {14'd0, bank}, 16'd2);
    access(2'b01, 8'h03, 1'b1, 8'h22, "R5 reg write bank2");
    access(2'b00, 8'h13, 1'b0, 8'h00, "R5 bank2 R3 location");
    access(2'b01, 8'h01, 1'b1, 8'hC4, "R4 set bank2 R1");
    access(2'b10, 8'h01, 1'b1, 8'h5E, "R4 indirect via R1");
    access(2'b10, 8'h01, 1'b0, 8'h00, "R4 readback via R1");
    access(2'b00, 8'hD0, 1'b1, 8'h18, "R6 status bank3");
    idle();
    check("R6 bank3", {14'd0, bank}, 16'd3);
    access(2'b01, 8'h07, 1'b1, 8'h99, "R5 reg write bank3 R7");
    access(2'b00, 8'h1F, 1'b0, 8'h00, "R5 bank3 R7 location");
    loadPtr(16'hBEEF);
    idle();
    check("R7 dptr out", dptr, 16'hBEEF);
    access(2'b00, 8'h83, 1'b0, 8'h00, "R7 high byte");
    access(2'b00, 8'h82, 1'b0, 8'h00, "R7 low byte");
    access(2'b00, 8'h05, 1'b1, 8'h5A, "R9 old value on write");
    access(2'b00, 8'h05, 1'b0, 8'h00, "R9 new value next access");
    access(2'b11, 8'h05, 1'b0, 8'h00, "R10 mode 11 as direct");
    for (int i = 8'h20; i < 8'h30; i++) access(2'b00, i[7:0], 1'b1, 8'(i * 7 + 3), "R2 pattern write");
    for (int i = 8'h20; i < 8'h30; i++) access(2'b00, i[7:0], 1'b0, 8'h00, "R2 pattern read");
    idle();
    idle();
    idle();
    check("R8 all results returned", 16'(expQ.size()), 16'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule